// File: doc/BRIEF.md
# Serial Frame Control-Word Inserter

This block places up to two 16-bit codec control words into an outgoing serial audio frame. A serializer runs beside it. On every bit of the frame the block says whether it takes over that bit position (`ins_valid`) and, if so, which bit value to send (`ins_bit`). The serializer muxes those two outputs into its own stream. Each control word has its own start position and its own enable. When both words cover the same bit, word 1 is the one sent.

Software writes the words and a shared configuration register through a simple write port. These writes go into staging registers. The staged values move into the active registers at the next frame boundary, so a frame is never built from a mix of old and new settings. A busy flag is raised by a write and drops at the frame boundary that takes the staged values in. Frame timing comes from a one-cycle `frame_start` pulse, and each clock cycle is one serial bit. The bit counter keeps running while transmission is disabled. In that state nothing is inserted.

Top module: `ctlword_inserter`

## Requirements
- R1: After reset, `busy` and `ins_valid` are 0, both enables are 0, and all readable registers return 0.
- R2: Register addresses are: 0 = staged word 1, 1 = staged word 2, 2 = staged configuration, 3 = none. The configuration holds word-1 position in bits [6:0], word-1 enable in bit 7, word-2 position in bits [14:8] and word-2 enable in bit 15. `rd_data` shows the register selected by `rd_addr` one cycle later. Address 3 reads as 0.
- R3: A write to addresses 0, 1 or 2 sets `busy` in the next cycle. `busy` stays set until the clock edge that samples `frame_start`, and then it clears. If a write arrives in the same cycle as `frame_start`, `busy` stays set.
- R4: Staged values take effect only at the edge that samples `frame_start`. Every bit of a frame already in progress uses the previous active values.
- R5: The cycle after the edge that samples `frame_start` carries frame bit 0. Each later cycle carries the next bit index.
- R6: An enabled word at position P is sent MSB first. At bit index P+k (k = 0..15), `ins_valid` = 1 and `ins_bit` = word[15-k].
- R7: A word whose enable is 0 is never inserted.
- R8: Where the bit ranges of two enabled words overlap, word 1 is sent.
- R9: Bit indices at or beyond FRAME_BITS are never reached. A word placed there, or the part of a word that runs past the frame end, is not sent. After the last bit of a frame, `ins_valid` stays 0 until the next `frame_start`.
- R10: While `tx_en` is low, `ins_valid` is 0. Bit counting and the staged-to-active transfer still happen.
- R11: Whenever `ins_valid` is 0, `ins_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Allows insertion when high |
| frame_start | input | 1 | One-cycle pulse; the next cycle is frame bit 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | Staged values waiting for a frame boundary |
| ins_valid | output | 1 | Block overrides this frame bit |
| ins_bit | output | 1 | Override bit value |

## Verification
A wrong bit counter or a wrong position comparison shows up within a single frame, as a word shifted or cut off on `ins_valid`. A wrong active register shows up in the first frame after a boundary, because the inserted bits differ from the staged words. An early transfer is caught by writing in the middle of a frame: a fault makes the tail of that same frame carry the new words. A stuck or early-clearing `busy` is visible in the cycle after a write or after a frame boundary.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;
  localparam int WORD_W = 16;
  localparam int POS_W  = 7;
  localparam int SEL_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ADDR_WORD1 = 2'd0,
    ADDR_WORD2 = 2'd1,
    ADDR_CFG   = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             en;
    logic [POS_W-1:0] pos;
  } lane_cfg_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    lane_cfg_t         cfg;
  } lane_t;
endpackage

// File: rtl/ctlword_regs.sv
module ctlword_regs
  import ctlword_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_start,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [1:0]                rd_addr,
  output logic [WORD_W-1:0]         rd_data,
  output logic                      busy,
  output lane_t [LANES-1:0]         act_nxt
);
  logic [LANES-1:0][WORD_W-1:0] stg_word;
  lane_cfg_t [LANES-1:0]        stg_cfg;
  lane_t [LANES-1:0]            act_q;
  logic                         wr_hit;

  assign wr_hit = wr_en && (wr_addr != ADDR_NONE);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (frame_start) begin
        act_nxt[i] = '{word: stg_word[i], cfg: stg_cfg[i]};
      end else begin
        act_nxt[i] = act_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_word <= '0;
      stg_cfg  <= '0;
      act_q    <= '0;
      busy     <= 1'b0;
      rd_data  <= '0;
    end else begin
      act_q <= act_nxt;
      if (wr_en) begin
        case (wr_addr)
          ADDR_WORD1: stg_word[0] <= wr_data;
          ADDR_WORD2: stg_word[1] <= wr_data;
          ADDR_CFG:   {stg_cfg[1], stg_cfg[0]} <= wr_data;
          default: ;
        endcase
      end
      if (wr_hit) begin
        busy <= 1'b1;
      end else if (frame_start) begin
        busy <= 1'b0;
      end
      case (rd_addr)
        ADDR_WORD1: rd_data <= stg_word[0];
        ADDR_WORD2: rd_data <= stg_word[1];
        ADDR_CFG:   rd_data <= {stg_cfg[1], stg_cfg[0]};
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ctlword_bitcnt.sv
module ctlword_bitcnt #(
  parameter int FRAME_BITS = 64,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  output logic [CNT_W-1:0] idx_nxt
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] idx_q;

  always_comb begin
    if (frame_start) begin
      idx_nxt = '0;
    end else if (idx_q == IDLE) begin
      idx_nxt = idx_q;
    end else begin
      idx_nxt = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= IDLE;
    end else begin
      idx_q <= idx_nxt;
    end
  end
endmodule

// File: rtl/ctlword_lane.sv
module ctlword_lane
  import ctlword_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int CNT_W      = 8
) (
  input  logic [CNT_W-1:0] idx,
  input  lane_t            lane,
  output logic             hit,
  output logic             bit_val
);
  logic [CNT_W-1:0] pos_ext;
  logic [CNT_W-1:0] ofs;
  logic [SEL_W-1:0] sel;
  logic             in_frame;
  logic             past_start;

  always_comb begin
    pos_ext    = CNT_W'(lane.cfg.pos);
    in_frame   = idx < CNT_W'(FRAME_BITS);
    past_start = idx >= pos_ext;
    ofs        = idx - pos_ext;
    sel        = SEL_W'(WORD_W - 1) - ofs[SEL_W-1:0];
    hit        = lane.cfg.en && in_frame && past_start && (ofs < CNT_W'(WORD_W));
    bit_val    = hit && lane.word[sel];
  end
endmodule

// File: rtl/ctlword_inserter.sv
module ctlword_inserter
  import ctlword_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              frame_start,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              ins_valid,
  output logic              ins_bit
);
  localparam int LANES  = 2;
  localparam int FB_W   = $clog2(FRAME_BITS + 1);
  localparam int CNT_W  = ((FB_W > POS_W) ? FB_W : POS_W) + 1;

  lane_t [LANES-1:0] act_nxt;
  logic [CNT_W-1:0]  idx_nxt;
  logic [LANES-1:0]  hit;
  logic [LANES-1:0]  lane_bit;
  logic              valid_d;
  logic              bit_d;

  ctlword_regs #(.LANES(LANES)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .busy        (busy),
    .act_nxt     (act_nxt)
  );

  ctlword_bitcnt #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .idx_nxt     (idx_nxt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ctlword_lane #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_lane (
      .idx     (idx_nxt),
      .lane    (act_nxt[g]),
      .hit     (hit[g]),
      .bit_val (lane_bit[g])
    );
  end

  always_comb begin
    valid_d = tx_en && (|hit);
    if (hit[0]) begin
      bit_d = lane_bit[0];
    end else begin
      bit_d = lane_bit[1];
    end
    bit_d = bit_d && valid_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_valid <= 1'b0;
      ins_bit   <= 1'b0;
    end else begin
      ins_valid <= valid_d;
      ins_bit   <= bit_d;
    end
  end
endmodule

// File: rtl/ctlword_inserter_chk.sv
module ctlword_inserter_chk #(
  parameter int FRAME_BITS = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic       frame_start,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       busy,
  input logic       ins_valid,
  input logic       ins_bit
);
  localparam int CW = $clog2(FRAME_BITS + 1) + 1;

  logic [CW-1:0] since_start;
  logic          wr_any;

  assign wr_any = wr_en && (wr_addr != 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_start <= CW'(FRAME_BITS);
    end else if (frame_start) begin
      since_start <= '0;
    end else if (since_start < CW'(FRAME_BITS)) begin
      since_start <= since_start + 1'b1;
    end
  end

  AST_WRITE_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_any |=> busy); // R3
  AST_FRAME_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !wr_any) |=> !busy); // R3
  AST_BUSY_STICKS: assert property (@(posedge clk) disable iff (rst)
    (busy && !frame_start) |=> busy); // R3
  AST_TX_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !ins_valid); // R10
  AST_IDLE_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |-> !ins_bit); // R11
  AST_NO_EMIT_PAST_END: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> (since_start < CW'(FRAME_BITS))); // R9
endmodule

bind ctlword_inserter ctlword_inserter_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .frame_start (frame_start),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .busy        (busy),
  .ins_valid   (ins_valid),
  .ins_bit     (ins_bit)
);

// File: tb/ctlword_inserter_bench.sv
module ctlword_inserter_bench;
  localparam int FB = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0;
  logic        frame_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        busy;
  logic        ins_valid;
  logic        ins_bit;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] s_w [2];
  int          s_p [2];
  bit          s_e [2];
  logic [15:0] m_w [2];
  int          m_p [2];
  bit          m_e [2];
  bit          m_tx = 1'b0;

  ctlword_inserter #(.FRAME_BITS(FB)) u_ctlword_inserter (
    .clk(clk), .rst(rst), .tx_en(tx_en), .frame_start(frame_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .ins_valid(ins_valid), .ins_bit(ins_bit)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(int k);
    if (!m_tx || k >= FB) return 2'b00;
    for (int i = 0; i < 2; i++) begin
      if (m_e[i] && k >= m_p[i] && k < m_p[i] + 16) return {1'b1, m_w[i][15 - (k - m_p[i])]};
    end
    return 2'b00;
  endfunction

  task automatic stage(input logic [1:0] a, input logic [15:0] d);
    case (a)
      2'd0: s_w[0] = d;
      2'd1: s_w[1] = d;
      2'd2: begin
        s_p[0] = int'(d[6:0]);  s_e[0] = d[7];
        s_p[1] = int'(d[14:8]); s_e[1] = d[15];
      end
      default: ;
    endcase
  endtask

  task automatic commit();
    for (int i = 0; i < 2; i++) begin
      m_w[i] = s_w[i]; m_p[i] = s_p[i]; m_e[i] = s_e[i];
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    stage(a, d);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic start_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    commit();
  endtask

  task automatic set_tx(input bit v);
    tx_en = v;
    @(negedge clk);
    m_tx = v;
  endtask

  task automatic check_span(input int lo, input int n, input string tag);
    int bad_k = -1;
    logic [1:0] bad_a = 2'b00;
    logic [1:0] bad_e = 2'b00;
    for (int k = lo; k < lo + n; k++) begin
      if ({ins_valid, ins_bit} !== model(k) && bad_k < 0) begin
        bad_k = k; bad_a = {ins_valid, ins_bit}; bad_e = model(k);
      end
      @(negedge clk);
    end
    if (bad_k < 0) chk(tag, 32'd0, 32'd0);
    else chk(tag, {22'd0, bad_k[7:0], bad_a}, {22'd0, bad_k[7:0], bad_e});
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 ins_valid after reset", 32'(ins_valid), 32'd0);
    rd_chk(2'd0, 16'h0000, "R1 word1 reset");
    rd_chk(2'd1, 16'h0000, "R1 word2 reset");
    rd_chk(2'd2, 16'h0000, "R1 cfg reset");
  endtask

  task automatic t_readback();
    wr(2'd0, 16'hA5C3);
    chk("R3 busy after write", 32'(busy), 32'd1);
    wr(2'd1, 16'h0F1E);
    wr(2'd2, {1'b1, 7'd30, 1'b1, 7'd4});
    rd_chk(2'd0, 16'hA5C3, "R2 word1 readback");
    rd_chk(2'd1, 16'h0F1E, "R2 word2 readback");
    rd_chk(2'd2, {1'b1, 7'd30, 1'b1, 7'd4}, "R2 cfg readback");
    rd_chk(2'd3, 16'h0000, "R2 address 3 reads zero");
    chk("R3 busy holds before frame", 32'(busy), 32'd1);
  endtask

  task automatic t_basic();
    start_frame();
    chk("R3 busy clears at frame start", 32'(busy), 32'd0);
    check_span(0, FB + 4, "R5 R6 R11 two words MSB first");
  endtask

  task automatic t_midframe();
    start_frame();
    check_span(0, 20, "R4 frame start before update");
    wr(2'd0, 16'h8001);
    wr(2'd1, 16'hFFFF);
    wr(2'd2, {1'b1, 7'd20, 1'b1, 7'd10});
    chk("R3 busy after mid-frame write", 32'(busy), 32'd1);
    check_span(23, FB + 4 - 23, "R4 rest of frame keeps old words");
    start_frame();
    check_span(0, FB + 4, "R8 overlap word1 wins");
  endtask

  task automatic t_disable();
    wr(2'd2, {1'b1, 7'd0, 1'b0, 7'd5});
    start_frame();
    check_span(0, FB + 4, "R7 disabled word1 absent");
  endtask

  task automatic t_past_end();
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'hBEEF);
    wr(2'd2, {1'b1, 7'd70, 1'b1, 7'd56});
    start_frame();
    check_span(0, FB + 6, "R9 truncation and unreachable position");
  endtask

  task automatic t_tx_off();
    set_tx(1'b0);
    wr(2'd2, {1'b1, 7'd40, 1'b1, 7'd0});
    start_frame();
    chk("R10 transfer continues with tx off", 32'(busy), 32'd0);
    check_span(0, FB + 2, "R10 silent while tx off");
    set_tx(1'b1);
    start_frame();
    check_span(0, FB + 2, "R10 resumes after tx on");
  endtask

  task automatic t_collide();
    frame_start = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h7E01;
    @(negedge clk);
    frame_start = 1'b0; wr_en = 1'b0;
    commit();
    stage(2'd0, 16'h7E01);
    chk("R3 write with frame start keeps busy", 32'(busy), 32'd1);
    check_span(0, FB + 2, "R4 collided frame uses previous words");
    start_frame();
    chk("R3 busy clears next frame", 32'(busy), 32'd0);
    check_span(0, FB + 2, "R4 collided write lands next frame");
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      s_w[i] = '0; s_p[i] = 0; s_e[i] = 1'b0;
    end
    commit();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    set_tx(1'b1);
    t_basic();
    t_midframe();
    t_disable();
    t_past_end();
    t_tx_off();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule